// File: doc/BRIEF.md
# GPIO Pad Level Resolver

This block holds the per-pin configuration of a 32-pin general-purpose I/O bank and resolves the level each pad settles to. Each pad can be driven by the block, by an external source, by both or by neither. The inputs that shape the result are the output value, a polarity inversion, the output enable, open-drain mode, pull-up, pull-down and an input mask. The external side supplies two vectors: whether each pin is driven from outside, and the level it is driven to.

Configuration is loaded through a one-cycle write port that selects one register by number. Three vectors are registered once per clock: the resolved pad level, a per-pin flag that marks contention or a floating pad, and the input value software would read. The input value from the previous cycle is also presented, so that an event detector downstream can compare two samples. The slew-rate and drive-strength vectors are only stored and passed to the pad ring.

Top module: `gpio_pin_resolver`

## Requirements
- R1: In push-pull mode with the output enabled, a pin's internal drive level is its output bit XOR its polarity bit, and that level appears on pinLevel.
- R2: When open-drain mode is set, a pin whose internal level is 1 is not driven, so its level comes from the pulls. A pin whose internal level is 0 is still driven low.
- R3: A pin that is driven internally and externally to different levels has its pinUndef bit set. Its level is the OR of the two drivers.
- R4: The resolved level is the external level where extDrv is set, ORed with the internal level where the internal driver is enabled. extLvl has no effect where extDrv is clear.
- R5: A pin driven by neither side reads 1 if its pull-up is on, and reads 0 and is defined if only its pull-down is on. It is undefined and reads 0 if neither pull is on.
- R6: dataIn equals (resolved level AND input mask) XOR polarity.
- R7: Reset clears the registered outputs and every configuration register, except pull-up, pull-down, slew and drive. Those four load the per-pin parameters RST_PULLUP, RST_PULLDOWN, RST_SLEW and RST_DRIVE.
- R8: pinLevel, pinUndef and dataIn change on the first clock edge after a change on extDrv or extLvl, and not before that edge. dataInPrev holds the value dataIn had one cycle earlier.
- R9: A write with wrEn high loads wrData into the register wrSel selects, on the next clock edge. The select codes are: 0 output, 1 polarity, 2 output enable, 3 open-drain, 4 pull-up, 5 pull-down, 6 input mask, 7 slew, 8 drive. Slew (7) and drive (8) appear only on padSlew and padDrive and do not change pinLevel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wrEn | input | 1 | Write strobe for the configuration registers |
| wrSel | input | 4 | Register select code |
| wrData | input | 32 | Value to write |
| extDrv | input | 32 | Per pin: an external source drives the pad |
| extLvl | input | 32 | Per pin: level of the external source |
| pinLevel | output | 32 | Registered resolved pad level |
| pinUndef | output | 32 | Registered flag: contention or floating pad |
| dataIn | output | 32 | Registered input data value |
| dataInPrev | output | 32 | dataIn delayed by one cycle |
| padSlew | output | 32 | Stored slew-rate selection |
| padDrive | output | 32 | Stored drive-strength selection |

## Verification
The hardest case to reach is a single configuration that produces contention, an open-drain release and a floating pin on neighbouring pins, with both polarity and the input mask active. Each stimulus vector therefore uses the low four pins for one such mix and sets pull-up on the other pins so they stay defined. A full round of register writes before each vector reaches these combinations, and a separate test changes the external lines just before a clock edge to show the one-cycle delay.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam int NUM_REGS = 9;
  localparam int SEL_W    = 4;

  typedef enum logic [SEL_W-1:0] {
    RegOut       = 4'd0,
    RegPol       = 4'd1,
    RegOe        = 4'd2,
    RegOpenDrain = 4'd3,
    RegPullUp    = 4'd4,
    RegPullDown  = 4'd5,
    RegInMask    = 4'd6,
    RegSlew      = 4'd7,
    RegDrive     = 4'd8
  } regSel_e;

  // one load strobe per configuration register
  typedef struct packed {
    logic [NUM_REGS-1:0] load;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_res_wr_ctl.sv
module gpio_res_wr_ctl
  import gpio_res_pkg::*;
(
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output wrStrobe_t        strobe
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign strobe.load[g] = wrEn && (wrSel == SEL_W'(g));
  end
endmodule

// File: rtl/gpio_res_cfg_regs.sv
module gpio_res_cfg_regs
  import gpio_res_pkg::*;
#(
  parameter int                NUM_PINS     = 32,
  parameter logic [NUM_PINS-1:0] RST_PULLUP   = '0,
  parameter logic [NUM_PINS-1:0] RST_PULLDOWN = '0,
  parameter logic [NUM_PINS-1:0] RST_SLEW     = '0,
  parameter logic [NUM_PINS-1:0] RST_DRIVE    = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  wrStrobe_t           strobe,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] cfgQ [NUM_REGS]
);
  function automatic logic [NUM_PINS-1:0] rstVal(int idx);
    case (idx)
      int'(RegPullUp):   return RST_PULLUP;
      int'(RegPullDown): return RST_PULLDOWN;
      int'(RegSlew):     return RST_SLEW;
      int'(RegDrive):    return RST_DRIVE;
      default:           return '0;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [NUM_PINS-1:0] INIT = rstVal(g);
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                cfgQ[g] <= INIT;
      else if (strobe.load[g]) cfgQ[g] <= wrData;
    end
  end
endmodule

// File: rtl/gpio_res_datapath.sv
module gpio_res_datapath #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] outData,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] oe,
  input  logic [NUM_PINS-1:0] openDrain,
  input  logic [NUM_PINS-1:0] pullUp,
  input  logic [NUM_PINS-1:0] pullDown,
  input  logic [NUM_PINS-1:0] inMask,
  input  logic [NUM_PINS-1:0] extDrv,
  input  logic [NUM_PINS-1:0] extLvl,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic [NUM_PINS-1:0] pinUndef,
  output logic [NUM_PINS-1:0] dataIn,
  output logic [NUM_PINS-1:0] dataInPrev
);
  logic [NUM_PINS-1:0] levelNxt, undefNxt, dinNxt;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic drvLvl, drvEn, idle, clash;
    assign drvLvl = outData[g] ^ pol[g];
    // open-drain pins only ever pull low
    assign drvEn  = oe[g] & ~(openDrain[g] & drvLvl);
    assign idle   = ~(drvEn | extDrv[g]);
    assign clash  = drvEn & extDrv[g] & (drvLvl ^ extLvl[g]);
    assign undefNxt[g] = clash | (idle & ~(pullUp[g] | pullDown[g]));
    assign levelNxt[g] = (extDrv[g] & extLvl[g]) | (drvEn & drvLvl) | (idle & pullUp[g]);
    assign dinNxt[g]   = (levelNxt[g] & inMask[g]) ^ pol[g];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pinLevel   <= '0;
      pinUndef   <= '0;
      dataIn     <= '0;
      dataInPrev <= '0;
    end else begin
      pinLevel   <= levelNxt;
      pinUndef   <= undefNxt;
      dataIn     <= dinNxt;
      dataInPrev <= dataIn;
    end
  end
endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver
  import gpio_res_pkg::*;
#(
  parameter int                NUM_PINS     = 32,
  parameter logic [NUM_PINS-1:0] RST_PULLUP   = '0,
  parameter logic [NUM_PINS-1:0] RST_PULLDOWN = '0,
  parameter logic [NUM_PINS-1:0] RST_SLEW     = '0,
  parameter logic [NUM_PINS-1:0] RST_DRIVE    = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] extDrv,
  input  logic [NUM_PINS-1:0] extLvl,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic [NUM_PINS-1:0] pinUndef,
  output logic [NUM_PINS-1:0] dataIn,
  output logic [NUM_PINS-1:0] dataInPrev,
  output logic [NUM_PINS-1:0] padSlew,
  output logic [NUM_PINS-1:0] padDrive
);
  wrStrobe_t           strobe;
  logic [NUM_PINS-1:0] cfgQ [NUM_REGS];

  gpio_res_wr_ctl u_ctl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  gpio_res_cfg_regs #(
    .NUM_PINS     (NUM_PINS),
    .RST_PULLUP   (RST_PULLUP),
    .RST_PULLDOWN (RST_PULLDOWN),
    .RST_SLEW     (RST_SLEW),
    .RST_DRIVE    (RST_DRIVE)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (wrData),
    .cfgQ   (cfgQ)
  );

  gpio_res_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .outData    (cfgQ[RegOut]),
    .pol        (cfgQ[RegPol]),
    .oe         (cfgQ[RegOe]),
    .openDrain  (cfgQ[RegOpenDrain]),
    .pullUp     (cfgQ[RegPullUp]),
    .pullDown   (cfgQ[RegPullDown]),
    .inMask     (cfgQ[RegInMask]),
    .extDrv     (extDrv),
    .extLvl     (extLvl),
    .pinLevel   (pinLevel),
    .pinUndef   (pinUndef),
    .dataIn     (dataIn),
    .dataInPrev (dataInPrev)
  );

  assign padSlew  = cfgQ[RegSlew];
  assign padDrive = cfgQ[RegDrive];
endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] oe,
  input logic [NUM_PINS-1:0] pol,
  input logic [NUM_PINS-1:0] pullUp,
  input logic [NUM_PINS-1:0] pullDown,
  input logic [NUM_PINS-1:0] inMask,
  input logic [NUM_PINS-1:0] extDrv,
  input logic [NUM_PINS-1:0] extLvl,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic [NUM_PINS-1:0] pinUndef,
  input logic [NUM_PINS-1:0] dataIn,
  input logic [NUM_PINS-1:0] dataInPrev
);
  // an external high always wins the OR
  p_ext_high_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pinLevel & $past(extDrv & extLvl)) == $past(extDrv & extLvl)));

  // no driver, no internal enable, no pull-up: level must be low
  p_float_low_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pinLevel & $past(~extDrv & ~oe & ~pullUp)) == '0));

  // an idle pin with pull-down is defined
  p_pulldown_def_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pinUndef & $past(~extDrv & ~oe & pullDown)) == '0));

  // masked pins read back as their polarity bit
  p_masked_pol_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((dataIn ^ $past(pol)) & ~$past(inMask)) == '0));

  p_prev_sample_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dataInPrev == $past(dataIn)));
endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .oe         (cfgQ[gpio_res_pkg::RegOe]),
  .pol        (cfgQ[gpio_res_pkg::RegPol]),
  .pullUp     (cfgQ[gpio_res_pkg::RegPullUp]),
  .pullDown   (cfgQ[gpio_res_pkg::RegPullDown]),
  .inMask     (cfgQ[gpio_res_pkg::RegInMask]),
  .extDrv     (extDrv),
  .extLvl     (extLvl),
  .pinLevel   (pinLevel),
  .pinUndef   (pinUndef),
  .dataIn     (dataIn),
  .dataInPrev (dataInPrev)
);

// File: tb/sim_gpio_pin_resolver.sv
module sim_gpio_pin_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] extDrv = '0;
  logic [31:0] extLvl = '0;
  logic [31:0] pinLevel, pinUndef, dataIn, dataInPrev, padSlew, padDrive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_pin_resolver #(
    .NUM_PINS     (32),
    .RST_PULLUP   (32'h0000_FF00),
    .RST_PULLDOWN (32'h00FF_0000),
    .RST_SLEW     (32'h0000_0000),
    .RST_DRIVE    (32'h0000_000F)
  ) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .extDrv(extDrv), .extLvl(extLvl), .pinLevel(pinLevel), .pinUndef(pinUndef),
    .dataIn(dataIn), .dataInPrev(dataInPrev), .padSlew(padSlew), .padDrive(padDrive)
  );

  // fields: out, pol, oe, openDrain, pullUp, pullDown, inMask, extDrv, extLvl,
  //         expected level, expected undef, expected dataIn
  localparam logic [31:0] VEC [6][12] = '{
    '{32'h5, 32'h3, 32'hF, 32'h0, 32'hFFFF_FFF0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0,
      32'hFFFF_FFF6, 32'h0, 32'hFFFF_FFF5},
    '{32'h3, 32'h0, 32'hF, 32'hF, 32'hFFFF_FFF1, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0,
      32'hFFFF_FFF1, 32'h2, 32'hFFFF_FFF1},
    '{32'h3, 32'h0, 32'hF, 32'h0, 32'hFFFF_FFF0, 32'h0, 32'hFFFF_FFFF, 32'h5, 32'h6,
      32'hFFFF_FFF7, 32'h5, 32'hFFFF_FFF7},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'hC, 32'hFFFF_FFFF, 32'h3, 32'h1,
      32'hFFFF_FFF1, 32'h0, 32'hFFFF_FFF1},
    '{32'h0, 32'hF, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'hC, 32'h0000_FFFF, 32'h3, 32'h1,
      32'hFFFF_FFF1, 32'h0, 32'h0000_FFFE},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
      32'h0, 32'hFFFF_FFFF, 32'h0}
  };
  localparam string VTAG [6] = '{"R1", "R2", "R3", "R4", "R6", "R5"};

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R7: registered outputs are clear while reset is held
    repeat (3) @(negedge clk);
    check("R7", "pinLevel in reset", pinLevel, 32'h0);
    check("R7", "pinUndef in reset", pinUndef, 32'h0);
    check("R7", "dataIn in reset",   dataIn,   32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R7: pulls from parameters, input mask cleared
    check("R7", "pinLevel after reset", pinLevel, 32'h0000_FF00);
    check("R7", "pinUndef after reset", pinUndef, 32'hFF00_00FF);
    check("R7", "dataIn after reset",   dataIn,   32'h0);
    check("R7", "padDrive reset",       padDrive, 32'h0000_000F);
    check("R7", "padSlew reset",        padSlew,  32'h0);

    // R9 drives every vector through the write port
    for (int i = 0; i < 6; i++) begin
      for (int r = 0; r < 7; r++) wr(4'(r), VEC[i][r]);
      extDrv = VEC[i][7];
      extLvl = VEC[i][8];
      repeat (2) @(negedge clk);
      check(VTAG[i], "pinLevel", pinLevel, VEC[i][9]);
      check(VTAG[i], "pinUndef", pinUndef, VEC[i][10]);
      check(VTAG[i], "dataIn",   dataIn,   VEC[i][11]);
    end

    // R8: external change appears only after the next edge
    wr(4'd6, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R8", "dataIn settled", dataIn, 32'h0);
    extDrv = 32'h1; extLvl = 32'h1;
    #1;
    check("R8", "pinLevel before edge", pinLevel, 32'h0);
    @(negedge clk);
    check("R8", "pinLevel after edge", pinLevel, 32'h1);
    check("R8", "dataIn after edge",   dataIn,   32'h1);
    check("R8", "dataInPrev lag",      dataInPrev, 32'h0);
    @(negedge clk);
    check("R8", "dataInPrev follows",  dataInPrev, 32'h1);

    // R9: slew and drive are stored only
    held = pinLevel;
    wr(4'd7, 32'hA5A5_A5A5);
    wr(4'd8, 32'h5A5A_5A5A);
    repeat (2) @(negedge clk);
    check("R9", "padSlew",  padSlew,  32'hA5A5_A5A5);
    check("R9", "padDrive", padDrive, 32'h5A5A_5A5A);
    check("R9", "pinLevel unchanged", pinLevel, held);

    // R9: an out-of-range select loads nothing
    wr(4'd12, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R9", "pinLevel after bad select", pinLevel, held);
    check("R9", "padSlew after bad select",  padSlew,  32'hA5A5_A5A5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule